// File: doc/BRIEF.md
# Serial Flash Upper Status Byte Controller

This block keeps the upper status byte of a quad-capable serial flash memory model and applies a separate update rule to each bit. A command decoder in front of it supplies single-cycle strobes: write-register with a data byte, suspend and resume. The block also takes two busy levels, one for an erase and one for a program, and a power-cycle pulse. It returns the assembled byte and a pin-mode select. When the select is low, the two shared pins act as write-protect and hold inputs. When it is high, they act as quad data lines 2 and 3.

The byte mixes three kinds of bit. The complement and quad-enable bits are ordinary writable bits. The three security lock bits are one-time-programmable: a write can set them but never clear them. The two suspend flags are read-only and change only through suspend, resume or a power cycle. Non-volatile storage is modelled as retention across the power-cycle input. The synchronous active-low reset acts as the factory initialisation that loads every bit to its default.

Top module: `flash_status_upper_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every bit of `status_o` becomes 0 and `quad_mode_o` becomes 0.
- R2: The byte layout is: bit 7 erase-suspended flag, bit 6 complement, bits 5..3 lock bits for security regions 3..1, bit 2 program-suspended flag, bit 1 quad enable, bit 0 reserved.
- R3: `quad_mode_o` always equals bit 1 of `status_o`. A write that changes quad enable therefore changes `quad_mode_o` at the next rising edge.
- R4: A write-register strobe with `wel_i` high loads bit 6 and bit 1 from `wr_data_i[6]` and `wr_data_i[1]` at the next edge.
- R5: On an accepted write, each lock bit (bits 5..3) becomes the OR of its current value and the matching bit of `wr_data_i`. Each lock bit can be set on its own. Once a lock bit is 1, only `rst_n` returns it to 0.
- R6: A write-register strobe with `wel_i` low changes no bit.
- R7: Write data never changes bits 7 and 2.
- R8: A suspend strobe sets bit 7 if `erase_busy_i` is high and sets bit 2 if `prog_busy_i` is high. If neither busy input is high, both flags are unchanged.
- R9: A resume strobe clears bits 7 and 2 at the next edge. It takes precedence over a suspend strobe in the same cycle.
- R10: A `pwr_cycle_i` pulse clears bits 7 and 2 and keeps bits 6..3 and bit 1. Any command strobe in the same cycle is ignored.
- R11: Bit 0 of `status_o` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low factory initialisation |
| wr_reg_i | input | 1 | Write-register command strobe |
| wr_data_i | input | 8 | Data byte of the write-register command |
| wel_i | input | 1 | Write-enable latch level |
| suspend_i | input | 1 | Suspend command strobe |
| resume_i | input | 1 | Resume command strobe |
| erase_busy_i | input | 1 | An erase is in progress |
| prog_busy_i | input | 1 | A program is in progress |
| pwr_cycle_i | input | 1 | Power-down/power-up event |
| status_o | output | 8 | Upper status byte |
| quad_mode_o | output | 1 | 1: shared pins act as quad data lines; 0: write-protect and hold |

## Verification
Every registered bit changes one edge after the strobe that causes it. `quad_mode_o` has no extra delay beyond its register bit, so both results are due one cycle after the stimulus. The bench drives inputs on the falling edge. It advances its behavioural model at the next rising edge and compares the whole byte and the pin mode at the following falling edge, so every cycle is checked exactly when its result is due. Directed phases cover the lock, suspend, resume and power-cycle orderings, and a seeded random phase then mixes all strobes.

// File: rtl/fsr_pkg.sv
// Shared constants for the upper status byte controller.
// Assumes a fixed 8-bit byte; positions are decoded by the status readout path.
package fsr_pkg;
    localparam int REG_W       = 8;
    localparam int POS_SUS_ER  = 7;
    localparam int POS_CMP     = 6;
    localparam int NUM_LOCK    = 3;
    localparam int POS_LOCK_LO = 3;
    localparam int POS_LOCK_HI = POS_LOCK_LO + NUM_LOCK - 1;
    localparam int POS_SUS_PG  = 2;
    localparam int POS_QE      = 1;
    localparam int POS_RSVD    = 0;

    typedef struct packed {
        logic                cmp;
        logic [NUM_LOCK-1:0] lock;
        logic                qe;
    } nv_fields_t;
endpackage

// File: rtl/fsr_nv_bits.sv
// Retained bits: complement, quad enable and one-time-programmable locks.
// Assumes wr_en is already qualified by write-enable and power-cycle.
// Only rst_n (factory initialisation) returns these bits to defaults.
module fsr_nv_bits
    import fsr_pkg::*;
#(
    parameter int LOCKS = NUM_LOCK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             cmp_d,
    input  logic             qe_d,
    input  logic [LOCKS-1:0] lock_d,
    output logic             cmp_q,
    output logic             qe_q,
    output logic [LOCKS-1:0] lock_q
);
    // Plain writable bits: load on every accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= 1'b0;
            qe_q  <= 1'b0;
        end else if (wr_en) begin
            cmp_q <= cmp_d;
            qe_q  <= qe_d;
        end
    end

    // One sticky cell per lock bit.
    for (genvar g = 0; g < LOCKS; g++) begin : g_lock
        // Set-only cell: a write can raise the bit, nothing but reset lowers it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lock_q[g] <= 1'b0;
            else if (wr_en && lock_d[g])
                lock_q[g] <= 1'b1;
        end
    end
endmodule

// File: rtl/fsr_suspend_flags.sv
// Read-only suspend flags for erase and program.
// Assumes clr already includes the power-cycle event and has priority over set.
module fsr_suspend_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set,
    input  logic erase_busy,
    input  logic prog_busy,
    output logic sus_erase_q,
    output logic sus_prog_q
);
    // Clear wins, otherwise a suspend sets the flag of each busy operation.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sus_erase_q <= 1'b0;
            sus_prog_q  <= 1'b0;
        end else if (set) begin
            if (erase_busy) sus_erase_q <= 1'b1;
            if (prog_busy)  sus_prog_q  <= 1'b1;
        end
    end
endmodule

// File: rtl/flash_status_upper_ctrl.sv
// Upper status byte controller for a quad-capable serial flash model.
// Gates the command strobes, holds the bits with per-bit update rules and
// assembles the byte. Assumes strobes are single-cycle and already decoded.
module flash_status_upper_ctrl
    import fsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_reg_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             wel_i,
    input  logic             suspend_i,
    input  logic             resume_i,
    input  logic             erase_busy_i,
    input  logic             prog_busy_i,
    input  logic             pwr_cycle_i,
    output logic [REG_W-1:0] status_o,
    output logic             quad_mode_o
);
    logic       wr_accept;
    logic       sus_clr;
    logic       sus_set;
    nv_fields_t nv_d;
    nv_fields_t nv_q;
    logic       sus_er_q;
    logic       sus_pg_q;
    logic       unused_wr_bits;

    // Command qualification: a power cycle masks every strobe.
    always_comb begin
        wr_accept = wr_reg_i && wel_i && !pwr_cycle_i;
        sus_clr   = resume_i || pwr_cycle_i;
        sus_set   = suspend_i && !pwr_cycle_i;
    end

    // Pick the writable fields out of the data byte.
    always_comb begin
        nv_d.cmp  = wr_data_i[POS_CMP];
        nv_d.lock = wr_data_i[POS_LOCK_HI:POS_LOCK_LO];
        nv_d.qe   = wr_data_i[POS_QE];
    end

    // Data bits at read-only and reserved positions are dropped.
    assign unused_wr_bits = ^{wr_data_i[POS_SUS_ER], wr_data_i[POS_SUS_PG],
                              wr_data_i[POS_RSVD]};

    fsr_nv_bits #(.LOCKS(NUM_LOCK)) u_nv (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_accept),
        .cmp_d  (nv_d.cmp),
        .qe_d   (nv_d.qe),
        .lock_d (nv_d.lock),
        .cmp_q  (nv_q.cmp),
        .qe_q   (nv_q.qe),
        .lock_q (nv_q.lock)
    );

    fsr_suspend_flags u_sus (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (sus_clr),
        .set         (sus_set),
        .erase_busy  (erase_busy_i),
        .prog_busy   (prog_busy_i),
        .sus_erase_q (sus_er_q),
        .sus_prog_q  (sus_pg_q)
    );

    // Byte assembly; the reserved position is tied low.
    always_comb begin
        status_o                          = '0;
        status_o[POS_SUS_ER]              = sus_er_q;
        status_o[POS_CMP]                 = nv_q.cmp;
        status_o[POS_LOCK_HI:POS_LOCK_LO] = nv_q.lock;
        status_o[POS_SUS_PG]              = sus_pg_q;
        status_o[POS_QE]                  = nv_q.qe;
        status_o[POS_RSVD]                = 1'b0;
    end

    // Pin mode follows quad enable without a further register.
    assign quad_mode_o = nv_q.qe;
endmodule

// File: rtl/fsr_status_chk.sv
// Property checker for flash_status_upper_ctrl, attached by bind.
// Assumes it sees only the top-level ports.
module fsr_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_reg_i,
    input logic       wel_i,
    input logic       suspend_i,
    input logic       resume_i,
    input logic       pwr_cycle_i,
    input logic [7:0] status_o,
    input logic       quad_mode_o
);
    logic seen;

    // Marks cycles whose previous cycle was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (status_o == 8'h00 && !quad_mode_o));

    // R3
    pin_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> quad_mode_o == status_o[1]);

    // R5
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> ((status_o[5:3] & $past(status_o[5:3])) == $past(status_o[5:3])));

    // R6
    wel_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(wr_reg_i && !wel_i && !suspend_i && !resume_i && !pwr_cycle_i))
        |-> $stable(status_o));

    // R7
    sus_write_immune_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(!suspend_i && !resume_i && !pwr_cycle_i))
        |-> (status_o[7] == $past(status_o[7]) && status_o[2] == $past(status_o[2])));

    // R9
    resume_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_i |=> (!status_o[7] && !status_o[2]));

    // R10
    pwr_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(pwr_cycle_i))
        |-> (!status_o[7] && !status_o[2] && status_o[6:3] == $past(status_o[6:3])
             && status_o[1] == $past(status_o[1])));

    // R11
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> !status_o[0]);
endmodule

bind flash_status_upper_ctrl fsr_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_reg_i    (wr_reg_i),
    .wel_i       (wel_i),
    .suspend_i   (suspend_i),
    .resume_i    (resume_i),
    .pwr_cycle_i (pwr_cycle_i),
    .status_o    (status_o),
    .quad_mode_o (quad_mode_o)
);

// File: tb/tb_flash_status_upper_ctrl.sv
module tb_flash_status_upper_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_reg_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic       wel_i = 1'b0;
    logic       suspend_i = 1'b0;
    logic       resume_i = 1'b0;
    logic       erase_busy_i = 1'b0;
    logic       prog_busy_i = 1'b0;
    logic       pwr_cycle_i = 1'b0;
    logic [7:0] status_o;
    logic       quad_mode_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // Behavioural reference state.
    int m_se, m_cmp, m_sp, m_qe;
    int m_lock[3];

    always #5 clk = ~clk;

    flash_status_upper_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_reg_i(wr_reg_i), .wr_data_i(wr_data_i),
        .wel_i(wel_i), .suspend_i(suspend_i), .resume_i(resume_i),
        .erase_busy_i(erase_busy_i), .prog_busy_i(prog_busy_i),
        .pwr_cycle_i(pwr_cycle_i), .status_o(status_o), .quad_mode_o(quad_mode_o)
    );

    function automatic logic [7:0] model_byte();
        return {m_se[0], m_cmp[0], m_lock[2][0], m_lock[1][0], m_lock[0][0],
                m_sp[0], m_qe[0], 1'b0};
    endfunction

    task automatic model_update();
        if (!rst_n) begin
            m_se = 0; m_cmp = 0; m_sp = 0; m_qe = 0;
            foreach (m_lock[i]) m_lock[i] = 0;
        end else if (pwr_cycle_i) begin
            m_se = 0; m_sp = 0;
        end else begin
            if (wr_reg_i && wel_i) begin
                m_cmp = wr_data_i[6];
                m_qe  = wr_data_i[1];
                for (int i = 0; i < 3; i++)
                    if (wr_data_i[3+i]) m_lock[i] = 1;
            end
            if (resume_i) begin
                m_se = 0; m_sp = 0;
            end else if (suspend_i) begin
                if (erase_busy_i) m_se = 1;
                if (prog_busy_i)  m_sp = 1;
            end
        end
    endtask

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    // One cycle: model follows the rising edge, outputs compared at the falling edge.
    task automatic step(string tag);
        logic [7:0] e;
        @(posedge clk);
        model_update();
        @(negedge clk);
        e = model_byte();
        check(tag, status_o, e);
        check("R3", {7'd0, quad_mode_o}, {7'd0, e[1]});
        check("R11", {7'd0, status_o[0]}, 8'd0);
    endtask

    task automatic idle();
        wr_reg_i = 0; wel_i = 0; suspend_i = 0; resume_i = 0;
        pwr_cycle_i = 0; wr_data_i = 8'h00;
    endtask

    task automatic wr(logic we, logic [7:0] d, string tag);
        idle(); wr_reg_i = 1; wel_i = we; wr_data_i = d;
        step(tag);
        idle();
    endtask

    task automatic sus(logic eb, logic pb, string tag);
        idle(); suspend_i = 1; erase_busy_i = eb; prog_busy_i = pb;
        step(tag);
        idle(); erase_busy_i = 0; prog_busy_i = 0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        @(negedge clk);
        rst_n = 0; step("R1"); step("R1");
        rst_n = 1;
        wr(1, 8'h42, "R4");            // CMP and QE set
        wr(0, 8'h00, "R6");            // ignored without write enable
        wr(0, 8'h38, "R6");            // locks not set either
        wr(1, 8'hFF, "R7");            // suspend flags untouched, locks set
        wr(1, 8'h00, "R5");            // locks stay, CMP/QE clear
        @(negedge clk); rst_n = 0; step("R1"); rst_n = 1;
        wr(1, 8'h10, "R5");            // only middle lock
        wr(1, 8'h08, "R5");            // lowest lock added
        wr(1, 8'h40, "R2");            // CMP alone lands on bit 6
        wr(1, 8'h02, "R2");            // QE alone lands on bit 1
        sus(1, 0, "R8");               // erase flag
        wr(1, 8'h00, "R7");
        idle(); resume_i = 1; step("R9"); idle();
        sus(0, 1, "R8");               // program flag
        sus(0, 0, "R8");               // nothing busy: unchanged
        idle(); suspend_i = 1; resume_i = 1; erase_busy_i = 1; step("R9");
        idle(); erase_busy_i = 0;
        sus(1, 1, "R8");               // both flags
        wr(1, 8'h22, "R4");
        idle(); pwr_cycle_i = 1; wr_reg_i = 1; wel_i = 1; wr_data_i = 8'h00;
        suspend_i = 1; erase_busy_i = 1; step("R10");
        idle(); erase_busy_i = 0;
        step("R10");
        // Mixed random traffic, checked every cycle.
        void'($urandom(32'h5eed));
        for (int n = 0; n < 400; n++) begin
            logic [7:0] r;
            r = 8'($urandom);
            rst_n        = (r[7:4] != 4'h0);
            wr_reg_i     = r[0];
            wel_i        = r[1];
            suspend_i    = r[2];
            resume_i     = r[3] & r[5];
            erase_busy_i = r[4];
            prog_busy_i  = r[5] ^ r[6];
            pwr_cycle_i  = (r[6:4] == 3'b111);
            wr_data_i    = 8'($urandom);
            step("R8");
        end
        idle(); rst_n = 1; step("R6");
        summary();
    end
endmodule